// File: doc/BRIEF.md
# Pairing FIFO with Programmable Fill Flags

This block is a synchronous first-in first-out buffer whose write port is half as wide as its read port. A producer pushes 16-bit samples with a write enable, and the block joins every two consecutive samples into one 32-bit entry. A host drains the entries through an active-low read strobe. The host typically drains in short bursts of eight reads with idle gaps between them, so it needs an early warning rather than a full flag.

That warning is the almost-full flag. Its threshold can be set only while the block is held in reset, and without a setting it is half the depth. A separate half-full flag, full and empty flags, and sticky error bits for a write into a full buffer or a read from an empty one are also provided. Both sides address the storage through internal ring pointers. A retransmit control rewinds the read side to a marked position, so stored entries can be read again without new writes.

Top module: `pkf_top`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears itself: after that edge `empty` is 1, and `full`, `half_full`, `almost_full`, `ovf_err` and `udf_err` are 0.
- R2: The first accepted write of a pair goes to bits 15:0 of an entry and the second goes to bits 31:16. The entry becomes readable, so that `empty` falls, only after the edge that accepts the second write.
- R3: Entries are read in write order. When `rd_n` is low at an edge and the buffer is not empty, `rd_data` shows the oldest entry after that edge. At any other time `rd_data` holds its value.
- R4: `full` is 1 when DEPTH entries are stored. A write while `full` is 1 is dropped, even if a read happens in the same cycle, and it sets `ovf_err`.
- R5: A read strobe while `empty` is 1 leaves `rd_data` and the pointers unchanged and sets `udf_err`.
- R6: `half_full` is 1 exactly when at least DEPTH/2 entries are stored.
- R7: `almost_full` is 1 exactly when the stored entry count is at least the threshold. The threshold takes `thr_in` at a reset edge where `thr_ld` is 1, and DEPTH/2 at a reset edge where `thr_ld` is 0. Outside reset, `thr_ld` has no effect.
- R8: `rt_go` moves the read position back to the mark, and the entry count follows. The mark is position 0 after reset, or the read position at the last edge with `rt_mark` high. `rt_go` takes priority over a read strobe in the same cycle, and that strobe is ignored.
- R9: `ovf_err` and `udf_err`, once set, stay set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| thr_ld | input | 1 | Loads the threshold from thr_in during reset |
| thr_in | input | 5 | Almost-full threshold, in entries |
| wr_en | input | 1 | Write enable for one 16-bit sample |
| wr_data | input | 16 | Write sample |
| rd_n | input | 1 | Active-low read strobe |
| rd_data | output | 32 | Registered read entry |
| rt_mark | input | 1 | Records the current read position as the mark |
| rt_go | input | 1 | Rewinds the read position to the mark |
| empty | output | 1 | No complete entries stored |
| full | output | 1 | DEPTH entries stored |
| half_full | output | 1 | At least DEPTH/2 entries stored |
| almost_full | output | 1 | Entry count at or above the threshold |
| ovf_err | output | 1 | Sticky: a write arrived while full |
| udf_err | output | 1 | Sticky: a read arrived while empty |

## Verification
A pointer or count that drifts by one shows within one edge: a fill flag changes a write too early or too late, or `empty` falls after half a pair. A wrong packing phase shows at the first read as swapped or stale 16-bit halves. A bad mark or rewind shows in the first word read after `rt_go`. A dropped or extra entry near the full boundary shows when the buffer is drained: the data sequence goes wrong, or `empty` rises at the wrong read.

// File: rtl/pkf_pkg.sv
package pkf_pkg;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } pack_phase_t;

    typedef struct packed {
        logic empty;
        logic full;
        logic half;
        logic afull;
    } flags_t;

endpackage

// File: rtl/pkf_packer.sv
module pkf_packer
    import pkf_pkg::*;
#(
    parameter int HW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            blocked,
    input  logic [HW-1:0]   wr_data,
    output logic            push,
    output logic [2*HW-1:0] push_word
);
    pack_phase_t phase;
    logic [HW-1:0] low_half;
    logic          take;

    assign take      = wr_en && !blocked;
    assign push      = take && (phase == PH_HIGH);
    assign push_word = {wr_data, low_half};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_LOW;
            low_half <= '0;
        end else if (take) begin
            if (phase == PH_LOW) begin
                low_half <= wr_data;
                phase    <= PH_HIGH;
            end else begin
                phase    <= PH_LOW;
            end
        end
    end
endmodule

// File: rtl/pkf_store.sv
module pkf_store #(
    parameter int W  = 32,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  push_word,
    input  logic          pop,
    input  logic          rt_mark,
    input  logic          rt_go,
    output logic [W-1:0]  rd_data,
    output logic [AW:0]   level
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp;
    logic [AW:0]  rp;
    logic [AW:0]  mark;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wp[AW-1:0]] <= push_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp      <= '0;
            rp      <= '0;
            mark    <= '0;
            rd_data <= '0;
        end else begin
            if (push) begin
                wp <= wp + 1'b1;
            end
            if (rt_go) begin
                rp <= mark;
            end else begin
                if (pop) begin
                    rd_data <= mem[rp[AW-1:0]];
                    rp      <= rp + 1'b1;
                end
                if (rt_mark) begin
                    mark <= rp;
                end
            end
        end
    end

    assign level = wp - rp;
endmodule

// File: rtl/pkf_flags.sv
module pkf_flags
    import pkf_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic [AW:0] level,
    input  logic [AW:0] thr,
    output flags_t      fl
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW:0] LVL_FULL = (AW+1)'(DEPTH);
    localparam logic [AW:0] LVL_HALF = (AW+1)'(DEPTH / 2);

    always_comb begin
        fl.empty = (level == '0);
        fl.full  = (level == LVL_FULL);
        fl.half  = (level >= LVL_HALF);
        fl.afull = (level >= thr);
    end
endmodule

// File: rtl/pkf_top.sv
module pkf_top
    import pkf_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        thr_ld,
    input  logic [$clog2(DEPTH):0]      thr_in,
    input  logic                        wr_en,
    input  logic [HALF_W-1:0]           wr_data,
    input  logic                        rd_n,
    output logic [2*HALF_W-1:0]         rd_data,
    input  logic                        rt_mark,
    input  logic                        rt_go,
    output logic                        empty,
    output logic                        full,
    output logic                        half_full,
    output logic                        almost_full,
    output logic                        ovf_err,
    output logic                        udf_err
);
    localparam int AW     = $clog2(DEPTH);
    localparam int FULL_W = 2 * HALF_W;
    localparam logic [AW:0] THR_DEFAULT = (AW+1)'(DEPTH / 2);

    flags_t             fl;
    logic [AW:0]        level;
    logic [AW:0]        thr;
    logic               push;
    logic [FULL_W-1:0]  push_word;
    logic               rd_req;
    logic               pop;

    assign rd_req = !rd_n && !rt_go;
    assign pop    = rd_req && !fl.empty;

    pkf_packer #(.HW(HALF_W)) u_pack (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .blocked   (fl.full),
        .wr_data   (wr_data),
        .push      (push),
        .push_word (push_word)
    );

    pkf_store #(.W(FULL_W), .AW(AW)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_word (push_word),
        .pop       (pop),
        .rt_mark   (rt_mark),
        .rt_go     (rt_go),
        .rd_data   (rd_data),
        .level     (level)
    );

    pkf_flags #(.AW(AW)) u_flags (
        .level (level),
        .thr   (thr),
        .fl    (fl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            thr     <= thr_ld ? thr_in : THR_DEFAULT;
            ovf_err <= 1'b0;
            udf_err <= 1'b0;
        end else begin
            if (wr_en && fl.full) begin
                ovf_err <= 1'b1;
            end
            if (rd_req && fl.empty) begin
                udf_err <= 1'b1;
            end
        end
    end

    assign empty       = fl.empty;
    assign full        = fl.full;
    assign half_full   = fl.half;
    assign almost_full = fl.afull;
endmodule

// File: rtl/pkf_chk.sv
module pkf_chk #(
    parameter int HALF_W = 16,
    parameter int DEPTH  = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   thr_ld,
    input logic [$clog2(DEPTH):0] thr_in,
    input logic                   wr_en,
    input logic [HALF_W-1:0]      wr_data,
    input logic                   rd_n,
    input logic [2*HALF_W-1:0]    rd_data,
    input logic                   rt_mark,
    input logic                   rt_go,
    input logic                   empty,
    input logic                   full,
    input logic                   half_full,
    input logic                   almost_full,
    input logic                   ovf_err,
    input logic                   udf_err
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (empty && !full && !ovf_err && !udf_err)); // R1

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        rd_n |=> $stable(rd_data)); // R3

    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(full && empty)); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en) |=> ovf_err); // R4

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (empty && !rd_n && !rt_go) |=> (udf_err && $stable(rd_data))); // R5

    AST_HALF_BELOW_FULL: assert property (@(posedge clk) disable iff (rst)
        full |-> half_full); // R6

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_err |=> ovf_err); // R9

    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (rst)
        udf_err |=> udf_err); // R9
endmodule

bind pkf_top pkf_chk #(.HALF_W(HALF_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_pkf_top.sv
module sim_pkf_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        thr_ld = 1'b0;
    logic [4:0]  thr_in = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_n = 1'b1;
    logic [31:0] rd_data;
    logic        rt_mark = 1'b0;
    logic        rt_go = 1'b0;
    logic        empty, full, half_full, almost_full, ovf_err, udf_err;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkf_top u0 (
        .clk(clk), .rst(rst), .thr_ld(thr_ld), .thr_in(thr_in),
        .wr_en(wr_en), .wr_data(wr_data), .rd_n(rd_n), .rd_data(rd_data),
        .rt_mark(rt_mark), .rt_go(rt_go), .empty(empty), .full(full),
        .half_full(half_full), .almost_full(almost_full),
        .ovf_err(ovf_err), .udf_err(udf_err)
    );

    function automatic logic [31:0] word(input int i);
        return {16'hA000 + 16'(2*i + 1), 16'hA000 + 16'(2*i)};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    task automatic do_reset(input bit ld, input logic [4:0] val);
        rst = 1'b1; thr_ld = ld; thr_in = val;
        tick(); tick();
        rst = 1'b0; thr_ld = 1'b0;
    endtask

    task automatic wr16(input logic [15:0] d);
        wr_en = 1'b1; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic wr32(input logic [31:0] w);
        wr16(w[15:0]);
        wr16(w[31:16]);
    endtask

    task automatic rd1();
        rd_n = 1'b0;
        tick();
        rd_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset(1'b0, 5'd0);
        chk_eq("R1 empty", 32'(empty), 32'd1);
        chk_eq("R1 flags", {28'd0, full, half_full, almost_full, ovf_err}, 32'd0);
        chk_eq("R1 udf", 32'(udf_err), 32'd0);
    endtask

    task automatic t_pack();
        do_reset(1'b0, 5'd0);
        wr16(16'h1111);
        chk_eq("R2 empty after half", 32'(empty), 32'd1);
        wr16(16'h2222);
        chk_eq("R2 not empty after pair", 32'(empty), 32'd0);
        rd1();
        chk_eq("R2 packed order", rd_data, 32'h2222_1111);
        chk_eq("R2 empty after drain", 32'(empty), 32'd1);
    endtask

    task automatic t_order();
        do_reset(1'b0, 5'd0);
        for (int i = 0; i < 3; i++) wr32(word(i));
        for (int i = 0; i < 3; i++) begin
            rd1();
            chk_eq("R3 read order", rd_data, word(i));
        end
        tick();
        chk_eq("R3 hold without strobe", rd_data, word(2));
    endtask

    task automatic t_fill();
        do_reset(1'b0, 5'd0);
        for (int i = 0; i < DEPTH; i++) begin
            wr32(word(i));
            if (i == 6) begin
                chk_eq("R6 half below", 32'(half_full), 32'd0);
                chk_eq("R7 afull below default", 32'(almost_full), 32'd0);
            end
            if (i == 7) begin
                chk_eq("R6 half at", 32'(half_full), 32'd1);
                chk_eq("R7 afull at default", 32'(almost_full), 32'd1);
            end
            if (i == 14) chk_eq("R4 not full yet", 32'(full), 32'd0);
        end
        chk_eq("R4 full", 32'(full), 32'd1);
        chk_eq("R4 no ovf yet", 32'(ovf_err), 32'd0);
        wr16(16'hDEAD);
        wr16(16'hBEEF);
        chk_eq("R4 ovf set", 32'(ovf_err), 32'd1);
        for (int i = 0; i < DEPTH; i++) begin
            rd1();
            chk_eq("R4 drain data", rd_data, word(i));
        end
        chk_eq("R4 empty after drain", 32'(empty), 32'd1);
        rd1();
        chk_eq("R5 rd_data kept", rd_data, word(DEPTH-1));
        chk_eq("R5 udf set", 32'(udf_err), 32'd1);
        wr32(word(40));
        rd1();
        chk_eq("R5 ptr unchanged", rd_data, word(40));
        chk_eq("R9 ovf sticky", 32'(ovf_err), 32'd1);
        chk_eq("R9 udf sticky", 32'(udf_err), 32'd1);
        do_reset(1'b0, 5'd0);
        chk_eq("R9 cleared by reset", {30'd0, ovf_err, udf_err}, 32'd0);
    endtask

    task automatic t_thresh();
        do_reset(1'b1, 5'd3);
        wr32(word(0)); wr32(word(1));
        chk_eq("R7 below loaded thr", 32'(almost_full), 32'd0);
        wr32(word(2));
        chk_eq("R7 at loaded thr", 32'(almost_full), 32'd1);
        chk_eq("R6 half low with thr 3", 32'(half_full), 32'd0);
        do_reset(1'b0, 5'd0);
        thr_ld = 1'b1; thr_in = 5'd1;
        tick();
        thr_ld = 1'b0;
        wr32(word(0));
        chk_eq("R7 load outside reset ignored", 32'(almost_full), 32'd0);
    endtask

    task automatic t_retx();
        do_reset(1'b0, 5'd0);
        for (int i = 0; i < 4; i++) wr32(word(i));
        rd1(); rd1();
        chk_eq("R8 pre-rewind", rd_data, word(1));
        rt_go = 1'b1; tick(); rt_go = 1'b0;
        for (int i = 0; i < 4; i++) begin
            rd1();
            chk_eq("R8 replay from reset mark", rd_data, word(i));
        end
        chk_eq("R8 empty after replay", 32'(empty), 32'd1);
        rt_go = 1'b1; tick(); rt_go = 1'b0;
        chk_eq("R8 count restored", 32'(empty), 32'd0);
        rd1();
        rt_mark = 1'b1; tick(); rt_mark = 1'b0;
        rd1(); rd1();
        chk_eq("R8 after mark", rd_data, word(2));
        rt_go = 1'b1; rd_n = 1'b0; tick(); rt_go = 1'b0; rd_n = 1'b1;
        chk_eq("R8 rewind beats read", rd_data, word(2));
        chk_eq("R8 no udf on rewind", 32'(udf_err), 32'd0);
        rd1();
        chk_eq("R8 replay from new mark", rd_data, word(1));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_pack();
        t_order();
        t_fill();
        t_thresh();
        t_retx();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule